// File: doc/BRIEF.md
# Page Access Check and Fault Encoder

This block sits after address translation in a 32-bit memory management path. For each access it receives the access kind, the privilege level, the flags of the selected segment, the two protection bits of the matched page entry, a data-access class and a flag that says the table lookup found nothing. In the same cycle it produces the read, write and execute permissions, an allow flag, the kind of exception to raise, and the fault code words. The permissions and fault outputs are purely combinational.

Segments flagged for direct store take a separate path. In that path the access class decides the outcome, and the page protection bits and lookup result play no part. When a request marked valid ends in a data fault or an alignment exception, a small register captures the effective address so that a fault address register can be loaded from it. The captured value is visible one clock later.

Top module: `page_access_guard`

## Requirements
- R1: `fault_addr` is 0 while reset is held. It takes `eff_addr` at the clock edge where `req_valid` is 1 and `exc_kind` is 2 or 3. At every other edge it holds its value, including edges with instruction faults, allowed accesses, or `req_valid` at 0.
- R2: `exc_kind` uses 0 for none, 1 for an instruction fault, 2 for a data fault and 3 for alignment. `allow` is 1 exactly when `exc_kind` is 0. `ifault_code` is 0 unless `exc_kind` is 1, and `dfault_status` is 0 unless `exc_kind` is 2. `acc_kind` uses 0 for fetch, 1 for load and 2 for store, and 3 behaves as a load.
- R3: The selected key is `seg_key_user` when `user_mode` is 1 and `seg_key_sup` when `user_mode` is 0.
- R4: In a normal segment with a lookup hit, the permissions are decoded from `page_pp` and the selected key. With key 0, values 0, 1 and 2 give read and write, and 3 gives read only. With key 1, 0 gives nothing, 1 and 3 give read only, and 2 gives read and write. Execute equals read unless `seg_noexec` is 1. The access is allowed when a fetch has execute, a load has read, or a store has write.
- R5: In a normal segment, a fetch with `seg_noexec` set raises an instruction fault with code 0x10000000. This takes precedence over a lookup miss.
- R6: In a normal segment, a lookup miss clears all permissions. A fetch then gets code 0x40000000, a load gets status 0x40000000 and a store gets status 0x42000000.
- R7: In a normal segment, a denied hit gives a fetch code 0x08000000, a load status 0x08000000 and a store status 0x0A000000.
- R8: In a direct-store segment, a fetch is always denied with instruction fault code 0x10000000 and all permissions 0, whatever the class, protection bits or lookup flag.
- R9: In a direct-store segment, a data access of class 1 (floating) raises an alignment exception with all permissions 0.
- R10: In a direct-store segment, class 2 (reservation) gives a data fault with status 0x04000000 on a load and 0x06000000 on a store. Class 4 (external control) gives 0x04100000 on a load and 0x06100000 on a store. Both leave the permissions at 0.
- R11: In a direct-store segment, class 3 (cache maintenance) is always allowed, with read and write set and execute clear.
- R12: In a direct-store segment, class 0 (integer) and the unused classes 5 to 7 always get read, get write only when the selected key is 1, and never get execute. A store without write raises a data fault with status 0x0A000000. `page_pp`, `seg_noexec` and `lookup_miss` have no effect in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault address register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Marks a real request, which gates the address capture |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| user_mode | input | 1 | 1 for a user-level access |
| seg_key_sup | input | 1 | Segment key applied to privileged accesses |
| seg_key_user | input | 1 | Segment key applied to user accesses |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| seg_direct | input | 1 | Segment is a direct-store segment |
| page_pp | input | 2 | Protection bits of the matched page entry |
| data_class | input | 3 | 0 integer, 1 floating, 2 reservation, 3 cache op, 4 external |
| lookup_miss | input | 1 | Table lookup found no entry |
| eff_addr | input | AW | Effective address of the access |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| perm_ex | output | 1 | Execute permitted |
| allow | output | 1 | The access may proceed |
| exc_kind | output | 2 | Exception to raise |
| ifault_code | output | 32 | Instruction fault code |
| dfault_status | output | 32 | Data fault status word |
| fault_addr | output | AW | Captured effective address of the last data or alignment fault |

## Verification
The bench builds the block with the default 32-bit address width, which is the width every code word and the fault address assume. The input space apart from the address is small. The bench therefore walks all 8192 combinations of access kind, privilege, both keys, no-execute, direct store, protection bits, all eight class codes and the miss flag. This covers every precedence between direct store, no-execute, miss and protection, along with the unused class and access encodings. The address and `req_valid` vary across the walk, so capture and hold of the fault address are seen after every outcome kind.

// File: rtl/pag_pkg.sv
package pag_pkg;

  localparam int CODE_W = 32;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_IFLT  = 2'd1,
    EXC_DFLT  = 2'd2,
    EXC_ALIGN = 2'd3
  } exc_e;

  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLOAT = 3'd1;
  localparam logic [2:0] CLS_RSV   = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  localparam logic [CODE_W-1:0] IC_NOEXEC  = 32'h1000_0000;
  localparam logic [CODE_W-1:0] IC_MISS    = 32'h4000_0000;
  localparam logic [CODE_W-1:0] IC_PROT    = 32'h0800_0000;

  localparam logic [CODE_W-1:0] DS_MISS_LD = 32'h4000_0000;
  localparam logic [CODE_W-1:0] DS_MISS_ST = 32'h4200_0000;
  localparam logic [CODE_W-1:0] DS_PROT_LD = 32'h0800_0000;
  localparam logic [CODE_W-1:0] DS_PROT_ST = 32'h0A00_0000;
  localparam logic [CODE_W-1:0] DS_RSV_LD  = 32'h0400_0000;
  localparam logic [CODE_W-1:0] DS_RSV_ST  = 32'h0600_0000;
  localparam logic [CODE_W-1:0] DS_EXT_LD  = 32'h0410_0000;
  localparam logic [CODE_W-1:0] DS_EXT_ST  = 32'h0610_0000;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

endpackage

// File: rtl/pag_perm_decode.sv
module pag_perm_decode
  import pag_pkg::*;
(
  input  logic       user_mode,
  input  logic       key_sup,
  input  logic       key_user,
  input  logic       noexec,
  input  logic [1:0] pp,
  output logic       key_sel,
  output perm_t      perm
);

  always_comb begin
    key_sel = user_mode ? key_user : key_sup;
    perm    = '0;
    if (!key_sel) begin
      perm.rd = 1'b1;
      perm.wr = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0:    begin perm.rd = 1'b0; perm.wr = 1'b0; end
        2'd2:    begin perm.rd = 1'b1; perm.wr = 1'b1; end
        default: begin perm.rd = 1'b1; perm.wr = 1'b0; end
      endcase
    end
    perm.ex = perm.rd & ~noexec;
  end

endmodule

// File: rtl/pag_fault_encode.sv
module pag_fault_encode
  import pag_pkg::*;
(
  input  logic [1:0]        acc_kind,
  input  logic              seg_noexec,
  input  logic              seg_direct,
  input  logic [2:0]        data_class,
  input  logic              lookup_miss,
  input  logic              key_sel,
  input  perm_t             page_perm,
  output perm_t             perm,
  output exc_e              exc,
  output logic [CODE_W-1:0] icode,
  output logic [CODE_W-1:0] dstat
);

  logic is_fetch;
  logic is_store;
  logic need_ok;

  always_comb begin
    is_fetch = (acc_e'(acc_kind) == ACC_FETCH);
    is_store = (acc_e'(acc_kind) == ACC_STORE);
    need_ok  = is_fetch ? page_perm.ex : (is_store ? page_perm.wr : page_perm.rd);
  end

  always_comb begin
    perm  = '0;
    exc   = EXC_NONE;
    icode = '0;
    dstat = '0;
    if (seg_direct) begin
      if (is_fetch) begin
        exc   = EXC_IFLT;
        icode = IC_NOEXEC;
      end else begin
        unique case (data_class)
          CLS_FLOAT: exc = EXC_ALIGN;
          CLS_RSV: begin
            exc   = EXC_DFLT;
            dstat = is_store ? DS_RSV_ST : DS_RSV_LD;
          end
          CLS_EXT: begin
            exc   = EXC_DFLT;
            dstat = is_store ? DS_EXT_ST : DS_EXT_LD;
          end
          CLS_CACHE: begin
            perm.rd = 1'b1;
            perm.wr = 1'b1;
          end
          default: begin
            perm.rd = 1'b1;
            perm.wr = key_sel;
            if (is_store && !key_sel) begin
              exc   = EXC_DFLT;
              dstat = DS_PROT_ST;
            end
          end
        endcase
      end
    end else if (is_fetch && seg_noexec) begin
      perm  = page_perm;
      exc   = EXC_IFLT;
      icode = IC_NOEXEC;
    end else if (lookup_miss) begin
      if (is_fetch) begin
        exc   = EXC_IFLT;
        icode = IC_MISS;
      end else begin
        exc   = EXC_DFLT;
        dstat = is_store ? DS_MISS_ST : DS_MISS_LD;
      end
    end else begin
      perm = page_perm;
      if (!need_ok) begin
        if (is_fetch) begin
          exc   = EXC_IFLT;
          icode = IC_PROT;
        end else begin
          exc   = EXC_DFLT;
          dstat = is_store ? DS_PROT_ST : DS_PROT_LD;
        end
      end
    end
  end

endmodule

// File: rtl/pag_addr_hold.sv
module pag_addr_hold #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  logic [AW-1:0] q_r;
  logic [AW-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/page_access_guard.sv
module page_access_guard
  import pag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_kind,
  input  logic              user_mode,
  input  logic              seg_key_sup,
  input  logic              seg_key_user,
  input  logic              seg_noexec,
  input  logic              seg_direct,
  input  logic [1:0]        page_pp,
  input  logic [2:0]        data_class,
  input  logic              lookup_miss,
  input  logic [AW-1:0]     eff_addr,
  output logic              perm_rd,
  output logic              perm_wr,
  output logic              perm_ex,
  output logic              allow,
  output logic [1:0]        exc_kind,
  output logic [CODE_W-1:0] ifault_code,
  output logic [CODE_W-1:0] dfault_status,
  output logic [AW-1:0]     fault_addr
);

  logic  key_sel;
  perm_t page_perm;
  perm_t perm;
  exc_e  exc;
  logic  cap_en;

  pag_perm_decode u_perm (
    .user_mode (user_mode),
    .key_sup   (seg_key_sup),
    .key_user  (seg_key_user),
    .noexec    (seg_noexec),
    .pp        (page_pp),
    .key_sel   (key_sel),
    .perm      (page_perm)
  );

  pag_fault_encode u_enc (
    .acc_kind    (acc_kind),
    .seg_noexec  (seg_noexec),
    .seg_direct  (seg_direct),
    .data_class  (data_class),
    .lookup_miss (lookup_miss),
    .key_sel     (key_sel),
    .page_perm   (page_perm),
    .perm        (perm),
    .exc         (exc),
    .icode       (ifault_code),
    .dstat       (dfault_status)
  );

  always_comb begin
    cap_en = req_valid && ((exc == EXC_DFLT) || (exc == EXC_ALIGN));
  end

  pag_addr_hold #(.AW(AW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (cap_en),
    .d       (eff_addr),
    .q       (fault_addr)
  );

  assign perm_rd  = perm.rd;
  assign perm_wr  = perm.wr;
  assign perm_ex  = perm.ex;
  assign exc_kind = exc;
  assign allow    = (exc == EXC_NONE);

endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    acc_kind,
  input logic          user_mode,
  input logic          seg_key_sup,
  input logic          seg_key_user,
  input logic          seg_noexec,
  input logic          seg_direct,
  input logic [1:0]    page_pp,
  input logic [2:0]    data_class,
  input logic          lookup_miss,
  input logic [AW-1:0] eff_addr,
  input logic          perm_rd,
  input logic          perm_wr,
  input logic          perm_ex,
  input logic          allow,
  input logic [1:0]    exc_kind,
  input logic [31:0]   ifault_code,
  input logic [31:0]   dfault_status,
  input logic [AW-1:0] fault_addr
);

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && exc_kind[1]) |=> (fault_addr == $past(eff_addr)));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && exc_kind[1]) |=> $stable(fault_addr));

  a_r2_codes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> (ifault_code == 32'h0 && dfault_status == 32'h0));

  a_r5_noexec_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_direct && seg_noexec && acc_kind == 2'd0) |-> (exc_kind == 2'd1 && ifault_code == 32'h1000_0000));

  a_r6_miss_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_direct && lookup_miss && acc_kind == 2'd2) |-> (dfault_status == 32'h4200_0000 && !perm_wr));

  a_r8_direct_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_direct && acc_kind == 2'd0) |-> (!allow && !perm_ex && ifault_code == 32'h1000_0000));

  a_r9_direct_float: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_direct && acc_kind != 2'd0 && data_class == 3'd1) |-> (exc_kind == 2'd3));

  a_r11_direct_cache: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_direct && acc_kind != 2'd0 && data_class == 3'd3) |-> (allow && perm_rd && perm_wr && !perm_ex));

  a_r12_direct_int_read: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_direct && acc_kind != 2'd0 && (data_class == 3'd0 || data_class > 3'd4)) |-> (perm_rd && !perm_ex));

endmodule

bind page_access_guard pag_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_page_access_guard.sv
`timescale 1ns/1ps
module tb_page_access_guard;

  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    acc_kind;
  logic          user_mode, seg_key_sup, seg_key_user, seg_noexec, seg_direct;
  logic [1:0]    page_pp;
  logic [2:0]    data_class;
  logic          lookup_miss;
  logic [AW-1:0] eff_addr;
  logic          perm_rd, perm_wr, perm_ex, allow;
  logic [1:0]    exc_kind;
  logic [31:0]   ifault_code, dfault_status;
  logic [AW-1:0] fault_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  page_access_guard #(.AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference: {rd, wr, ex, allow, exc[1:0], icode[31:0], dstat[31:0]}
  function automatic logic [69:0] ref_eval(
    input int ak, input bit um, input bit ks, input bit ku, input bit nx,
    input bit dr, input int pp, input int cls, input bit miss);
    bit key, rd, wr, ex, fetch, store;
    int ek;
    logic [31:0] ic, ds;
    fetch = (ak == 0);
    store = (ak == 2);
    key = um ? ku : ks;
    rd = 0; wr = 0; ex = 0; ek = 0; ic = 0; ds = 0;
    if (dr) begin
      if (fetch) begin ek = 1; ic = 32'h1000_0000; end
      else if (cls == 1) ek = 3;
      else if (cls == 2) begin ek = 2; ds = store ? 32'h0600_0000 : 32'h0400_0000; end
      else if (cls == 4) begin ek = 2; ds = store ? 32'h0610_0000 : 32'h0410_0000; end
      else if (cls == 3) begin rd = 1; wr = 1; end
      else begin
        rd = 1; wr = key;
        if (store && !key) begin ek = 2; ds = 32'h0A00_0000; end
      end
    end else begin
      bit prd, pwr, pex, ok;
      if (key == 0) begin prd = 1; pwr = (pp < 3); end
      else begin prd = (pp != 0); pwr = (pp == 2); end
      pex = prd && !nx;
      ok = fetch ? pex : (store ? pwr : prd);
      if (fetch && nx) begin rd = prd; wr = pwr; ex = pex; ek = 1; ic = 32'h1000_0000; end
      else if (miss) begin
        if (fetch) begin ek = 1; ic = 32'h4000_0000; end
        else begin ek = 2; ds = store ? 32'h4200_0000 : 32'h4000_0000; end
      end else begin
        rd = prd; wr = pwr; ex = pex;
        if (!ok) begin
          if (fetch) begin ek = 1; ic = 32'h0800_0000; end
          else begin ek = 2; ds = store ? 32'h0A00_0000 : 32'h0800_0000; end
        end
      end
    end
    return {rd, wr, ex, (ek == 0), 2'(ek), ic, ds};
  endfunction

  function automatic string pick_tag(input int ak, input bit ks, input bit ku,
    input bit nx, input bit dr, input int cls, input bit miss, input bit ok);
    if (dr) begin
      if (ak == 0) return "R8";
      if (cls == 1) return "R9";
      if (cls == 2 || cls == 4) return "R10";
      if (cls == 3) return "R11";
      return "R12";
    end
    if (ak == 0 && nx) return "R5";
    if (miss) return "R6";
    if (ks != ku) return "R3";
    return ok ? "R4" : "R7";
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] exp_fa;
    logic [AW-1:0] pend_fa;
    rst_n = 1'b0; req_valid = 1'b0; acc_kind = 2'd1; user_mode = 1'b0;
    seg_key_sup = 1'b0; seg_key_user = 1'b0; seg_noexec = 1'b0; seg_direct = 1'b0;
    page_pp = 2'd0; data_class = 3'd0; lookup_miss = 1'b1; eff_addr = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R1 reset", 128'(fault_addr), 128'(0));
    @(posedge clk); #1 rst_n = 1'b1;
    exp_fa = '0;
    for (int idx = 0; idx < 8192; idx++) begin
      logic [69:0] exp_v;
      logic [69:0] act_v;
      string tag;
      acc_kind     = idx[1:0];
      user_mode    = idx[2];
      seg_key_sup  = idx[3];
      seg_key_user = idx[4];
      seg_noexec   = idx[5];
      seg_direct   = idx[6];
      page_pp      = idx[8:7];
      data_class   = idx[11:9];
      lookup_miss  = idx[12];
      req_valid    = ((idx % 3) != 0);
      eff_addr     = 32'(idx) * 32'h9E37_79B1 + 32'h1357_0000;
      @(negedge clk);
      exp_v = ref_eval(int'(acc_kind), user_mode, seg_key_sup, seg_key_user, seg_noexec,
                       seg_direct, int'(page_pp), int'(data_class), lookup_miss);
      act_v = {perm_rd, perm_wr, perm_ex, allow, exc_kind, ifault_code, dfault_status};
      tag = pick_tag(int'(acc_kind), seg_key_sup, seg_key_user, seg_noexec, seg_direct,
                     int'(data_class), lookup_miss, exp_v[66]);
      check(tag, 128'(act_v), 128'(exp_v));
      // R2: allow/exception/code consistency seen at the ports
      check("R2", 128'({allow, (exc_kind == 2'd1) || (ifault_code == 0),
                        (exc_kind == 2'd2) || (dfault_status == 0)}),
                  128'({(exc_kind == 2'd0), 1'b1, 1'b1}));
      // R1: captured address from the previous request
      check("R1", 128'(fault_addr), 128'(exp_fa));
      pend_fa = exp_fa;
      if (req_valid && (exp_v[65:64] == 2'd2 || exp_v[65:64] == 2'd3)) pend_fa = eff_addr;
      @(posedge clk); #1;
      exp_fa = pend_fa;
    end
    @(negedge clk);
    check("R1 final", 128'(fault_addr), 128'(exp_fa));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule